// File: doc/BRIEF.md
# Submission Queue Run-Time Controller

This block is the per-queue run-time control and status logic of a multi-queue storage host controller. Software reaches it through a small register port. It writes a control register to stop, start or clean up the queue, and it writes a command-identifier register to name one outstanding command. It reads a status register to see the outcome. The block drives a fetch-enable line to the queue's entry-fetch logic. Stop and start are not applied at once: a stop waits until any entry fetch in progress has finished, and software learns that fetching has halted from a status bit.

While the queue is halted, a cleanup request searches a small table of outstanding commands for the one whose LUN and tag match the identifier register. A match is invalidated so the command is never processed. The search visits one slot per cycle. The block raises a done bit and reports a 4-bit result code. The table is filled by an issue strobe from the fetch side and emptied by a retire strobe when commands complete.

Top module: `sq_runtime_ctrl`

## Requirements
- R1: After reset, fetch_en_o is 1, the status and identifier registers read 0 and entry_valid_o is 0.
- R2: The identifier register at byte offset 0xC reads back all 32 written bits. The status register at 0x10 reads {24'b0, code[3:0], 2'b0, done, stopped}. Offsets 0x0, 0x4 and 0x8 read 0. Writes to 0x0, 0x4 and 0x10 change nothing.
- R3: Writing 0x1 to offset 0x8 (stop) drives fetch_en_o to 0 from the write edge on. The stopped bit (status bit 0) is set at the first later edge at which fetch_busy_i is 0, and it is never set while fetch_busy_i stays 1.
- R4: Writing 0x0 to offset 0x8 (start) drives fetch_en_o to 1 and clears the stopped bit at the write edge.
- R5: Control values other than 0x0, 0x1 and 0x2 are ignored. Status and fetch_en_o do not change.
- R6: Writing 0x2 (cleanup) while stopped searches slots 0 upward for a valid entry equal to identifier bits 15:0 (tag in bits 7:0, LUN in bits 15:8). When slot k matches, its entry is invalidated, done (status bit 1) is set and the code is 0x0, all k+1 edges after the write edge.
- R7: A cleanup that finds no matching entry sets done with code 0x2 after DEPTH edges and leaves the table unchanged.
- R8: A cleanup requested while not stopped sets done with code 0x1 at the write edge. The table is unchanged and fetch_en_o is unaffected.
- R9: Any accepted control write clears done. The code keeps its last value until the next cleanup result.
- R10: An issue strobe stores issue_id_i in the lowest free slot and is dropped when all slots are full. A retire strobe invalidates the lowest valid slot holding retire_id_i.
- R11: Identifier bits 31:16 take no part in the cleanup match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte offset within the queue window |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| fetch_busy_i | input | 1 | An entry fetch is in progress |
| fetch_en_o | output | 1 | Permission for the fetch logic to start new entries |
| issue_valid_i | input | 1 | Record a newly fetched command |
| issue_id_i | input | ID_W | LUN and tag of the fetched command |
| retire_valid_i | input | 1 | A command has completed |
| retire_id_i | input | ID_W | LUN and tag of the completed command |
| entry_valid_o | output | DEPTH | Valid bit of each table slot |

## Verification
The assertions assume that software follows the expected order of stop, wait for stopped, cleanup, wait for done, then start. They also assume that retire strobes name only commands that are present in the table. Control writes made while a search is running are not relied upon. The bench keeps within these limits. It waits for each status transition before the next control write, and it retires only identifiers that it issued earlier. When it issues to a full table, it does so only to observe that the command is dropped.

// File: rtl/sq_rtc_pkg.sv
package sq_rtc_pkg;
  localparam int unsigned OFF_HEAD   = 'h00;
  localparam int unsigned OFF_TAIL   = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_IDENT  = 'h0C;
  localparam int unsigned OFF_STATUS = 'h10;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_CLEAN = 2'd2,
    CMD_NONE  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_DRAIN,
    ST_HALT,
    ST_SCAN
  } state_e;

  localparam logic [3:0] RC_OK          = 4'h0;
  localparam logic [3:0] RC_NOT_STOPPED = 4'h1;
  localparam logic [3:0] RC_NO_MATCH    = 4'h2;
endpackage

// File: rtl/sq_rtc_regs.sv
module sq_rtc_regs
  import sq_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              stopped_i,
  input  logic              done_i,
  input  logic [3:0]        code_i,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [DATA_W-1:0] ident_o
);
  logic [DATA_W-1:0] ident_q;
  logic              sel_ctrl, sel_ident, sel_status;

  assign sel_ctrl   = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_ident  = (addr_i == ADDR_W'(OFF_IDENT));
  assign sel_status = (addr_i == ADDR_W'(OFF_STATUS));

  // only the three defined codes are accepted; anything else is dropped
  assign cmd_o       = cmd_e'(wdata_i[1:0]);
  assign cmd_valid_o = we_i && sel_ctrl && (wdata_i[DATA_W-1:2] == '0) && (wdata_i[1:0] != 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ident_q <= '0;
    else if (we_i && sel_ident) ident_q <= wdata_i;
  end

  assign ident_o = ident_q;

  always_comb begin
    rdata_o = '0;
    if (sel_ident)  rdata_o = ident_q;
    if (sel_status) rdata_o = {{(DATA_W-8){1'b0}}, code_i, 2'b00, done_i, stopped_i};
  end
endmodule

// File: rtl/sq_rtc_table.sv
module sq_rtc_table #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned ID_W  = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic [ID_W-1:0]  issue_id_i,
  input  logic             retire_valid_i,
  input  logic [ID_W-1:0]  retire_id_i,
  input  logic             inv_valid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [ID_W-1:0]  rd_id_o,
  output logic [DEPTH-1:0] valid_o
);
  logic [DEPTH-1:0] valid_q;
  logic [ID_W-1:0]  id_q [DEPTH];
  logic             free_hit, ret_hit;
  logic [IDX_W-1:0] free_idx, ret_idx;

  // lowest free slot and lowest matching valid slot
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    ret_hit  = 1'b0;
    ret_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (valid_q[i] && id_q[i] == retire_id_i) begin
        ret_hit = 1'b1;
        ret_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) id_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (issue_valid_i && free_hit && free_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          id_q[i]    <= issue_id_i;
        end else if ((retire_valid_i && ret_hit && ret_idx == IDX_W'(i)) ||
                     (inv_valid_i && rd_idx_i == IDX_W'(i))) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_id_o    = id_q[rd_idx_i];
  assign valid_o    = valid_q;
endmodule

// File: rtl/sq_rtc_fsm.sv
module sq_rtc_fsm
  import sq_rtc_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned ID_W  = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  cmd_e             cmd_i,
  input  logic [ID_W-1:0]  key_i,
  input  logic             fetch_busy_i,
  input  logic             rd_valid_i,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic             fetch_en_o,
  output logic             stopped_o,
  output logic             done_o,
  output logic [3:0]       code_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             inv_valid_o
);
  state_e           state_q;
  logic             done_q;
  logic [3:0]       code_q;
  logic [IDX_W-1:0] idx_q;
  logic [ID_W-1:0]  key_q;
  logic             hit;

  assign hit         = rd_valid_i && (rd_id_i == key_q);
  assign inv_valid_o = (state_q == ST_SCAN) && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      done_q  <= 1'b0;
      code_q  <= RC_OK;
      idx_q   <= '0;
      key_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN, ST_DRAIN: begin
          if (cmd_valid_i) done_q <= 1'b0;
          if (cmd_valid_i && cmd_i == CMD_CLEAN) begin
            done_q <= 1'b1;
            code_q <= RC_NOT_STOPPED;
          end
          if (state_q == ST_RUN) begin
            if (cmd_valid_i && cmd_i == CMD_STOP) state_q <= ST_DRAIN;
          end else if (cmd_valid_i && cmd_i == CMD_START) begin
            state_q <= ST_RUN;
          end else if (!fetch_busy_i) begin
            state_q <= ST_HALT;  // entry boundary reached
          end
        end
        ST_HALT: begin
          if (cmd_valid_i) begin
            done_q <= 1'b0;
            if (cmd_i == CMD_START) state_q <= ST_RUN;
            if (cmd_i == CMD_CLEAN) begin
              state_q <= ST_SCAN;
              idx_q   <= '0;
              key_q   <= key_i;
            end
          end
        end
        ST_SCAN: begin
          // control writes are not honoured during a search
          if (hit) begin
            done_q  <= 1'b1;
            code_q  <= RC_OK;
            state_q <= ST_HALT;
          end else if (idx_q == IDX_W'(DEPTH - 1)) begin
            done_q  <= 1'b1;
            code_q  <= RC_NO_MATCH;
            state_q <= ST_HALT;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign fetch_en_o = (state_q == ST_RUN);
  assign stopped_o  = (state_q == ST_HALT) || (state_q == ST_SCAN);
  assign done_o     = done_q;
  assign code_o     = code_q;
  assign rd_idx_o   = idx_q;
endmodule

// File: rtl/sq_runtime_ctrl.sv
module sq_runtime_ctrl
  import sq_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              fetch_busy_i,
  output logic              fetch_en_o,
  input  logic              issue_valid_i,
  input  logic [ID_W-1:0]   issue_id_i,
  input  logic              retire_valid_i,
  input  logic [ID_W-1:0]   retire_id_i,
  output logic [DEPTH-1:0]  entry_valid_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              sts_stopped, sts_done;
  logic [3:0]        sts_code;
  logic              cmd_valid;
  cmd_e              cmd;
  logic [DATA_W-1:0] ident;
  logic              rd_valid, inv_valid;
  logic [ID_W-1:0]   rd_id;
  logic [IDX_W-1:0]  rd_idx;

  sq_rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .stopped_i(sts_stopped), .done_i(sts_done), .code_i(sts_code),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .ident_o(ident)
  );

  sq_rtc_fsm #(.DEPTH(DEPTH), .ID_W(ID_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .key_i(ident[ID_W-1:0]),
    .fetch_busy_i(fetch_busy_i), .rd_valid_i(rd_valid), .rd_id_i(rd_id),
    .fetch_en_o(fetch_en_o), .stopped_o(sts_stopped), .done_o(sts_done), .code_o(sts_code),
    .rd_idx_o(rd_idx), .inv_valid_o(inv_valid)
  );

  sq_rtc_table #(.DEPTH(DEPTH), .ID_W(ID_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid_i), .issue_id_i(issue_id_i),
    .retire_valid_i(retire_valid_i), .retire_id_i(retire_id_i),
    .inv_valid_i(inv_valid), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_id_o(rd_id), .valid_o(entry_valid_o)
  );
endmodule

// File: rtl/sq_runtime_ctrl_chk.sv
module sq_runtime_ctrl_chk
  import sq_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              fetch_busy_i,
  input logic              fetch_en_o,
  input logic              retire_valid_i,
  input logic [DEPTH-1:0]  entry_valid_o,
  input logic              stopped,
  input logic              done,
  input logic [3:0]        code
);
  p_halt_after_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped) |-> !$past(fetch_busy_i));

  p_start_resumes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_en_o) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(OFF_CTRL) && reg_wdata_i == '0));

  p_reject_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done) && !stopped) |-> code == RC_NOT_STOPPED);

  p_table_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(entry_valid_o) < $past($countones(entry_valid_o)))
      |-> ($past(retire_valid_i) || ($rose(done) && code == RC_OK)));
endmodule

bind sq_runtime_ctrl sq_runtime_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .fetch_busy_i(fetch_busy_i), .fetch_en_o(fetch_en_o),
  .retire_valid_i(retire_valid_i), .entry_valid_o(entry_valid_o),
  .stopped(sts_stopped), .done(sts_done), .code(sts_code)
);

// File: tb/sq_runtime_ctrl_tb.sv
module sq_runtime_ctrl_tb;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int DEPTH  = 8;
  localparam logic [ADDR_W-1:0] A_HEAD = 5'h00, A_TAIL = 5'h04, A_CTRL = 5'h08,
                                A_IDENT = 5'h0C, A_STS = 5'h10;
  localparam logic [DEPTH-1:0] FULL = '1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;
  logic fetch_busy_i = 1'b0;
  logic fetch_en_o;
  logic issue_valid_i = 1'b0;
  logic [ID_W-1:0] issue_id_i = '0;
  logic retire_valid_i = 1'b0;
  logic [ID_W-1:0] retire_id_i = '0;
  logic [DEPTH-1:0] entry_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  sq_runtime_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .fetch_busy_i(fetch_busy_i), .fetch_en_o(fetch_en_o),
    .issue_valid_i(issue_valid_i), .issue_id_i(issue_id_i),
    .retire_valid_i(retire_valid_i), .retire_id_i(retire_id_i),
    .entry_valid_o(entry_valid_o)
  );

  function automatic logic [ID_W-1:0] mk_id(int j);
    return ID_W'(((j + 1) << 8) | (j * 3 + 5));
  endfunction

  function automatic logic [31:0] sts(int code, int done, int stopped);
    return 32'((code << 4) | (done << 1) | stopped);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_now(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic issue(logic [ID_W-1:0] id);
    @(negedge clk_i);
    issue_valid_i = 1'b1; issue_id_i = id;
    @(negedge clk_i);
    issue_valid_i = 1'b0;
  endtask

  task automatic retire(logic [ID_W-1:0] id);
    @(negedge clk_i);
    retire_valid_i = 1'b1; retire_id_i = id;
    @(negedge clk_i);
    retire_valid_i = 1'b0;
  endtask

  task automatic wait_done(output int polls, output logic [DATA_W-1:0] s);
    polls = 0;
    do begin
      rd(A_STS, s);
      polls++;
    end while (!s[1] && polls < 40);
  endtask

  initial begin
    logic [DATA_W-1:0] d;
    int polls;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_now(A_STS, d);   chk("R1 status", d, 0);
    rd_now(A_IDENT, d); chk("R1 ident", d, 0);
    chk("R1 fetch_en", 32'(fetch_en_o), 1);
    chk("R1 table", 32'(entry_valid_o), 0);

    // R2 register map
    wr(A_IDENT, 32'hDEAD_0305);
    rd_now(A_IDENT, d); chk("R2 ident readback", d, 32'hDEAD_0305);
    wr(A_HEAD, '1); wr(A_TAIL, '1); wr(A_STS, '1);
    rd_now(A_HEAD, d); chk("R2 head reads 0", d, 0);
    rd_now(A_TAIL, d); chk("R2 tail reads 0", d, 0);
    rd_now(A_CTRL, d); chk("R2 ctrl reads 0", d, 0);
    rd_now(A_STS, d);  chk("R2 status unaffected", d, 0);
    chk("R2 fetch_en unaffected", 32'(fetch_en_o), 1);

    // R10 fill the table
    for (int j = 0; j < DEPTH; j++) begin
      issue(mk_id(j));
      chk("R10 fill", 32'(entry_valid_o), 32'((1 << (j + 1)) - 1));
    end
    issue(16'hABCD);
    chk("R10 full drop", 32'(entry_valid_o), 32'(FULL));
    retire(mk_id(3));
    chk("R10 retire", 32'(entry_valid_o), 32'(FULL & ~(DEPTH'(1) << 3)));
    issue(mk_id(3));
    chk("R10 lowest free", 32'(entry_valid_o), 32'(FULL));

    // R8 cleanup while running
    wr(A_IDENT, 32'(mk_id(2)));
    wr(A_CTRL, 2);
    rd_now(A_STS, d); chk("R8 reject code", d, sts(1, 1, 0));
    chk("R8 table", 32'(entry_valid_o), 32'(FULL));
    chk("R8 fetch_en", 32'(fetch_en_o), 1);

    // R5 invalid control values
    wr(A_CTRL, 3);
    rd_now(A_STS, d); chk("R5 value 3 ignored", d, sts(1, 1, 0));
    wr(A_CTRL, 32'h101);
    rd_now(A_STS, d); chk("R5 value 0x101 ignored", d, sts(1, 1, 0));
    chk("R5 fetch_en", 32'(fetch_en_o), 1);

    // R9 start while running clears done
    wr(A_CTRL, 0);
    rd_now(A_STS, d); chk("R9 done cleared", d, sts(1, 0, 0));

    // R3 stop waits for fetch idle
    fetch_busy_i = 1'b1;
    wr(A_CTRL, 1);
    chk("R3 fetch_en drops", 32'(fetch_en_o), 0);
    repeat (5) @(negedge clk_i);
    rd_now(A_STS, d); chk("R3 not stopped while busy", d, sts(1, 0, 0));
    fetch_busy_i = 1'b0;
    @(negedge clk_i);
    rd_now(A_STS, d); chk("R3 stopped after idle", d, sts(1, 0, 1));

    // R6 / R11 sweep match position, junk in upper identifier bits
    for (int k = 0; k < DEPTH; k++) begin
      wr(A_IDENT, {8'(k * 17 + 1), 8'hA5, mk_id(k)});
      wr(A_CTRL, 2);
      wait_done(polls, d);
      chk("R6 code ok", d, sts(0, 1, 1));
      chk("R6 latency", 32'(polls), 32'(k + 1));
      chk("R11 entry removed", 32'(entry_valid_o), 32'(FULL & ~(DEPTH'(1) << k)));
      chk("R6 fetch stays off", 32'(fetch_en_o), 0);
      issue(mk_id(k));
    end

    // R7 no match
    wr(A_IDENT, 32'h0000_FFFF);
    wr(A_CTRL, 2);
    wait_done(polls, d);
    chk("R7 code", d, sts(2, 1, 1));
    chk("R7 latency", 32'(polls), 32'(DEPTH));
    chk("R7 table", 32'(entry_valid_o), 32'(FULL));

    // R9 stop while stopped clears done, keeps code
    wr(A_CTRL, 1);
    rd_now(A_STS, d); chk("R9 done cleared by stop", d, sts(2, 0, 1));

    // R4 start
    wr(A_CTRL, 0);
    chk("R4 fetch_en", 32'(fetch_en_o), 1);
    rd_now(A_STS, d); chk("R4 stopped cleared", d, sts(2, 0, 0));

    // R3 stop with idle fetch
    wr(A_CTRL, 1);
    chk("R3 fetch_en low", 32'(fetch_en_o), 0);
    @(negedge clk_i);
    rd_now(A_STS, d); chk("R3 stopped next edge", d, sts(2, 0, 1));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule